// File: doc/BRIEF.md
# Receive Line Idle and Timeout Detector

This block sits beside a serial receiver and decides when the receive line has gone quiet. It is given a strobe that marks the middle of each bit period, together with the line level sampled at that strobe. It counts how many consecutive mid-bit samples have read high. The span that counts as idle is set by the programmed character length: four times the number of data bits, plus twelve bit periods.

Two independent counters share the sample stream. The sleep counter runs at all times and restarts whenever a sample reads low. Its flag tells power management that the line is idle, and activity clears that flag. The timeout counter runs only while the receive FIFO holds at least one character. It restarts on a low sample or on a read of the receive data register. Its flag requests a timeout interrupt and stays set until the data is read or the FIFO empties. Baud-rate generation and the mid-bit strobe itself are provided by the receiver.

Top module: `rx_idle_timeout`

## Requirements
- R1: After a synchronous active-low reset, both `sleep_idle` and `rx_timeout` read 0 and both counts start from zero.
- R2: The idle span in bit periods is 4*(5+`word_len`)+12, where `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. This gives spans of 32, 36, 40 and 44.
- R3: `sleep_idle` reads 1 in the cycle after the clock edge that takes in the span-th consecutive high sample, where a sample is `samp_bit` while `samp_stb` is 1. With one high sample fewer, it still reads 0.
- R4: A low sample (`samp_stb`=1, `samp_bit`=0) clears `sleep_idle` in the next cycle and restarts the sleep count from zero.
- R5: While `samp_stb` is 0, the value of `samp_bit` has no effect on either count.
- R6: While `fifo_has_data` is 0, the timeout count is held at zero and `rx_timeout` stays 0. The sleep count is not affected by `fifo_has_data`.
- R7: A low sample or a `data_rd` pulse restarts the timeout count, so a further full span of high samples is needed before `rx_timeout` sets.
- R8: Once set, `rx_timeout` stays 1 through line activity and clears in the cycle after `data_rd` is 1 or `fifo_has_data` is 0.
- R9: When the line stays high past the span, the counts saturate and do not wrap, so `sleep_idle` stays 1 until the next low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_stb | input | 1 | One-cycle strobe at the middle of each bit period |
| samp_bit | input | 1 | Receive line level, valid while `samp_stb` is 1 |
| word_len | input | WLEN_W (2) | Character length code: 0 to 3 select 5 to 8 data bits |
| fifo_has_data | input | 1 | Receive FIFO holds at least one character |
| data_rd | input | 1 | One-cycle pulse on a read of the receive data register |
| sleep_idle | output | 1 | Line idle for a full span since the last activity |
| rx_timeout | output | 1 | Timeout interrupt request, sticky until read or FIFO empty |

## Verification
The bench sweeps all four character lengths and counts the high samples needed to raise each flag. A span that is off by one, or that ignores `word_len`, shows up as a wrong count. Toggling `samp_bit` between strobes catches a design that counts clock cycles instead of samples. Holding the line high well past the span catches a counter that wraps and drops the flag. Reads, line activity and FIFO-empty events are applied before and after the timeout flag sets. This catches a flag that activity wrongly clears, a flag that survives a read, and a count that keeps running while the FIFO is empty or resumes from a stale value.

// File: rtl/rx_idle_pkg.sv
// Package: shared constants and the idle-span formula for the receive
// idle/timeout detector. Assumes character length codes start at 5 bits.
package rx_idle_pkg;

    localparam int unsigned WORD_BASE  = 5;   // data bits for length code 0
    localparam int unsigned SPAN_MULT  = 4;   // bit periods per data bit
    localparam int unsigned SPAN_EXTRA = 12;  // fixed bit periods added

    // Channel index of the two parallel counters.
    typedef enum logic [0:0] {
        CH_SLEEP = 1'b0,
        CH_TMO   = 1'b1
    } idle_ch_e;

    // Idle span, in bit periods, for a given character length code.
    function automatic int unsigned span_bits(input int unsigned code);
        return SPAN_MULT * (WORD_BASE + code) + SPAN_EXTRA;
    endfunction

endpackage

// File: rtl/rx_idle_span.sv
// Module: converts the character length code into the idle span in bit
// periods. Pure combinational; assumes CNT_W holds the largest span.
module rx_idle_span #(
    parameter int unsigned WLEN_W = 2,
    parameter int unsigned CNT_W  = 6
) (
    input  logic [WLEN_W-1:0] word_len,
    output logic [CNT_W-1:0]  span
);
    // Evaluate the span formula for the current length code.
    always_comb begin
        span = CNT_W'(rx_idle_pkg::span_bits(32'(word_len)));
    end
endmodule

// File: rtl/rx_idle_cnt.sv
// Module: saturating count of consecutive qualifying samples. Restart has
// priority over advance. Reports whether the next value meets the span.
// Assumes the span is never zero.
module rx_idle_cnt #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] span,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit_next
);
    logic [CNT_W-1:0] cnt_d;

    // Next count: clear, step up to the span, or hold.
    always_comb begin
        if (restart) begin
            cnt_d = '0;
        end else if (advance && (cnt_q < span)) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        hit_next = (cnt_d >= span);
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rx_idle_flag.sv
// Module: set/clear flag register, clear wins. Assumes set and clear are
// single-cycle qualified conditions from the owning channel.
module rx_idle_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag_q
);
    // Flag register with clear priority and synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_idle_timeout.sv
// Module: receive idle detector with a sleep-idle channel and a FIFO-gated
// timeout channel sharing one mid-bit sample stream. Assumes samp_stb is
// one cycle per bit and samp_bit is valid with it.
module rx_idle_timeout #(
    parameter int unsigned WLEN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_stb,
    input  logic              samp_bit,
    input  logic [WLEN_W-1:0] word_len,
    input  logic              fifo_has_data,
    input  logic              data_rd,
    output logic              sleep_idle,
    output logic              rx_timeout
);
    import rx_idle_pkg::*;

    localparam int unsigned MAX_SPAN = span_bits((1 << WLEN_W) - 1);
    localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);
    localparam int unsigned N_CH     = 2;

    logic [CNT_W-1:0] span;
    logic [N_CH-1:0]  ch_restart;
    logic [N_CH-1:0]  ch_advance;
    logic [N_CH-1:0]  ch_clr;
    logic [N_CH-1:0]  ch_hit;
    logic [N_CH-1:0]  ch_flag;
    logic [CNT_W-1:0] ch_cnt [N_CH];
    logic             activity;
    logic             high_smp;
    logic [CNT_W-1:0] sleep_cnt;
    logic [CNT_W-1:0] tmo_cnt;

    rx_idle_span #(.WLEN_W(WLEN_W), .CNT_W(CNT_W)) u_span (
        .word_len (word_len),
        .span     (span)
    );

    // Classify the current strobe as activity (low) or a high sample.
    always_comb begin
        activity = samp_stb && !samp_bit;
        high_smp = samp_stb && samp_bit;
    end

    // Per-channel restart, advance and flag-clear rules.
    always_comb begin
        ch_restart[CH_SLEEP] = activity;
        ch_advance[CH_SLEEP] = high_smp;
        ch_clr[CH_SLEEP]     = activity;
        ch_restart[CH_TMO]   = activity || data_rd || !fifo_has_data;
        ch_advance[CH_TMO]   = high_smp && fifo_has_data;
        ch_clr[CH_TMO]       = data_rd || !fifo_has_data;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        rx_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (ch_restart[g]),
            .advance  (ch_advance[g]),
            .span     (span),
            .cnt_q    (ch_cnt[g]),
            .hit_next (ch_hit[g])
        );
        rx_idle_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (ch_hit[g]),
            .clr    (ch_clr[g]),
            .flag_q (ch_flag[g])
        );
    end

    // Drive the outputs and name the counts for the bound checker.
    always_comb begin
        sleep_idle = ch_flag[CH_SLEEP];
        rx_timeout = ch_flag[CH_TMO];
        sleep_cnt  = ch_cnt[CH_SLEEP];
        tmo_cnt    = ch_cnt[CH_TMO];
    end
endmodule

// File: rtl/rx_idle_timeout_chk.sv
// Checker: temporal properties of the idle detector, bound to the top.
module rx_idle_timeout_chk #(
    parameter int unsigned WLEN_W = 2,
    parameter int unsigned CNT_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             samp_stb,
    input logic             samp_bit,
    input logic             fifo_has_data,
    input logic             data_rd,
    input logic             sleep_idle,
    input logic             rx_timeout,
    input logic [CNT_W-1:0] sleep_cnt,
    input logic [CNT_W-1:0] tmo_cnt
);
    localparam int unsigned MAX_SPAN = rx_idle_pkg::span_bits((1 << WLEN_W) - 1);

    assert_rise_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_idle) |-> $past(samp_stb && samp_bit));

    assert_low_clears_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_stb && !samp_bit) |=> (!sleep_idle && sleep_cnt == '0));

    assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_stb |=> $stable(sleep_cnt));

    assert_empty_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_has_data |=> (tmo_cnt == '0 && !rx_timeout));

    assert_read_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> (tmo_cnt == '0 && !rx_timeout));

    assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_timeout && fifo_has_data && !data_rd) |=> rx_timeout);

    assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(sleep_cnt) <= MAX_SPAN) && (32'(tmo_cnt) <= MAX_SPAN));
endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.WLEN_W(WLEN_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .samp_stb      (samp_stb),
    .samp_bit      (samp_bit),
    .fifo_has_data (fifo_has_data),
    .data_rd       (data_rd),
    .sleep_idle    (sleep_idle),
    .rx_timeout    (rx_timeout),
    .sleep_cnt     (sleep_cnt),
    .tmo_cnt       (tmo_cnt)
);

// File: tb/rx_idle_timeout_tb.sv
// Bench: sweeps all character lengths with an arithmetic reference model.
module rx_idle_timeout_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_stb = 1'b0;
    logic       samp_bit = 1'b1;
    logic [1:0] word_len = 2'd0;
    logic       fifo_has_data = 1'b0;
    logic       data_rd = 1'b0;
    logic       sleep_idle;
    logic       rx_timeout;

    int errors = 0;
    int checks = 0;
    int m_s = 0, m_t = 0;
    bit m_sf = 0, m_tf = 0;

    always #10 clk = ~clk;

    rx_idle_timeout #(.WLEN_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb), .samp_bit(samp_bit),
        .word_len(word_len), .fifo_has_data(fifo_has_data), .data_rd(data_rd),
        .sleep_idle(sleep_idle), .rx_timeout(rx_timeout)
    );

    function automatic int span_of(input int code);
        return 4 * (5 + code) + 12;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model after posedge, compare at negedge.
    task automatic step(input bit stb, input bit lvl, input bit fifo, input bit rd, input string tag);
        int thr;
        samp_stb = stb; samp_bit = lvl; fifo_has_data = fifo; data_rd = rd;
        @(posedge clk);
        thr = span_of(int'(word_len));
        if (stb) begin
            if (!lvl) m_s = 0;
            else if (m_s < thr) m_s++;
        end
        if (stb && !lvl) m_sf = 0;
        else if (m_s >= thr) m_sf = 1;
        if (rd || !fifo || (stb && !lvl)) m_t = 0;
        else if (stb && lvl && m_t < thr) m_t++;
        if (rd || !fifo) m_tf = 0;
        else if (m_t >= thr) m_tf = 1;
        @(negedge clk);
        samp_stb = 1'b0; data_rd = 1'b0;
        check(tag, "sleep_idle", int'(sleep_idle), int'(m_sf));
        check(tag, "rx_timeout", int'(rx_timeout), int'(m_tf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; samp_stb = 1'b0; data_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_s = 0; m_t = 0; m_sf = 0; m_tf = 0;
        check("R1", "sleep_idle after reset", int'(sleep_idle), 0);
        check("R1", "rx_timeout after reset", int'(rx_timeout), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        for (int wl = 0; wl < 4; wl++) begin
            int thr;
            int first_s;
            int first_t;
            word_len = 2'(wl);
            thr = span_of(wl);
            first_s = -1; first_t = -1;
            step(1, 0, 1, 0, "R4");
            // Count high samples to each flag; low level between strobes is ignored.
            for (int k = 1; k <= thr + 4; k++) begin
                step(1, 1, 1, 0, "R3");
                if (first_s < 0 && sleep_idle) first_s = k;
                if (first_t < 0 && rx_timeout) first_t = k;
                step(0, 0, 1, 0, "R5");
                step(0, k[0], 1, 0, "R5");
            end
            check("R2", "high samples to sleep_idle", first_s, thr);
            check("R2", "high samples to rx_timeout", first_t, thr);
            check("R9", "sleep_idle held past span", int'(sleep_idle), 1);
            // Activity keeps the timeout flag; a read clears it.
            step(1, 0, 1, 0, "R8");
            check("R4", "sleep_idle after low sample", int'(sleep_idle), 0);
            check("R8", "rx_timeout kept through activity", int'(rx_timeout), 1);
            step(0, 1, 1, 1, "R8");
            check("R8", "rx_timeout after read", int'(rx_timeout), 0);
            // A read mid-count restarts the timeout span.
            for (int k = 0; k < 10; k++) step(1, 1, 1, 0, "R7");
            step(0, 1, 1, 1, "R7");
            for (int k = 0; k < thr - 1; k++) step(1, 1, 1, 0, "R7");
            check("R7", "rx_timeout one short after read", int'(rx_timeout), 0);
            step(1, 1, 1, 0, "R7");
            check("R7", "rx_timeout after full span", int'(rx_timeout), 1);
            // FIFO empty clears the flag and blocks counting; sleep keeps counting.
            step(1, 0, 0, 0, "R8");
            check("R8", "rx_timeout after FIFO empty", int'(rx_timeout), 0);
            for (int k = 0; k < thr + 2; k++) step(1, 1, 0, 0, "R6");
            check("R6", "rx_timeout while FIFO empty", int'(rx_timeout), 0);
            check("R6", "sleep_idle while FIFO empty", int'(sleep_idle), 1);
            for (int k = 0; k < thr - 1; k++) step(1, 1, 1, 0, "R6");
            check("R6", "rx_timeout one short after refill", int'(rx_timeout), 0);
            step(1, 1, 1, 0, "R6");
            check("R6", "rx_timeout full span after refill", int'(rx_timeout), 1);
            do_reset();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule